// File: doc/BRIEF.md
# Spare-Area ECC Layout Assembler

This block builds the spare (out-of-band) bytes of one NAND page from the per-chunk results of a 4-bit-correcting ECC engine. After every 512-byte data chunk the engine hands over four raw 32-bit words. Each word carries two 10-bit symbols, so a chunk yields eight symbols. The block keeps the symbol bits, packs the eight symbols densely into ten bytes and writes them into a spare buffer at positions that depend on the page size and the layout mode.

A new page is opened with a start pulse. The pulse latches the page size and the layout mode and fills the whole buffer with 0xFF. Before any chunk arrives, the caller may overwrite individual buffer bytes with its own spare contents. In standard layout the ECC bytes go to fixed positions that keep clear of the bad-block marker, and the caller streams the finished spare area out on request. In infix layout every chunk owns a 16-byte group of six pad bytes followed by its ten ECC bytes. That group streams out by itself as soon as packing ends, so it sits right behind the chunk's data, and no spare area follows the last chunk.

Top module: `spare_ecc_assembler`

## Requirements
- R1: After reset and after every page start, every buffer byte holds 0xFF. A standard read with no chunk written streams only 0xFF. The layout and page-size code at reset are standard and 512 bytes.
- R2: Raw word w (bits 32w+31..32w of the raw bus) gives symbol 2w from bits 9:0 and symbol 2w+1 from bits 25:16. All other bits have no effect. The eight symbols are concatenated with symbol 0 at the least significant end, and ECC byte k is bits 8k+7..8k of that 80-bit value.
- R3: With page-size code 0 (512 bytes, one chunk), ECC bytes 0..9 land at spare offsets 0, 1, 2, 3, 4, 6, 7, 13, 14 and 15. Offsets 5 and 8..12 are not touched.
- R4: With code 1 (2048 bytes, four chunks), ECC byte k of chunk c lands at offset 24+10c+k. With code 2 or 3 (4096 bytes, eight chunks), it lands at 48+10c+k.
- R5: Bytes written by the caller after the page start, and not covered by ECC, are returned unchanged.
- R6: In infix layout, after chunk c is packed, the block streams 16 bytes without a request: buffer offsets 16c..16c+5 (pad), then ECC bytes 0..9. out_last marks the 16th byte.
- R7: In infix layout a read request is ignored and produces no stream.
- R8: In standard layout an idle read request streams the spare area from offset 0, one byte per cycle. The length is 16, 64 or 128 bytes for codes 0, 1 and 2/3, and out_last marks the final byte only.
- R9: An accepted chunk raises busy at the strobe edge. In standard layout busy falls after exactly 10 cycles. In infix layout it falls after 10 packing cycles plus the 16 stream cycles.
- R10: A chunk strobe after the page's chunk count is reached is ignored: busy stays low and the buffer does not change.
- R11: A chunk strobe while busy is ignored and does not count toward the page's chunks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_start | input | 1 | Opens a new page: latches size and mode, fills buffer with 0xFF |
| page_size | input | 2 | Page size code: 0 = 512, 1 = 2048, 2/3 = 4096 bytes |
| infix_mode | input | 1 | 1 selects the infix layout, 0 the standard layout |
| sup_we | input | 1 | Writes one caller-supplied spare byte (only when idle) |
| sup_addr | input | 7 | Spare offset for the supplied byte |
| sup_data | input | 8 | Supplied byte value |
| chunk_done | input | 1 | Strobe: a data chunk finished, raw ECC words valid |
| ecc_raw | input | 128 | Four raw 32-bit ECC words, word 0 in bits 31:0 |
| read_req | input | 1 | Requests the standard-layout spare stream |
| busy | output | 1 | Packing or streaming in progress |
| out_valid | output | 1 | A spare byte is on out_data this cycle |
| out_data | output | 8 | Streamed spare byte |
| out_last | output | 1 | Final byte of the current stream |

## Verification
A wrong write pointer or chunk counter shows up as ECC bytes at shifted offsets, as a bad-block marker or reserved byte turned from 0xFF, or as a chunk that is silently dropped. All of these appear in the next spare stream, at the first mismatching byte. A packing fault (a wrong bit slice, a missed mask, a wrong byte order) corrupts the streamed ECC bytes of the same chunk, and in infix layout these reach the ports within 26 cycles of the strobe. Sequencing faults, such as a wrong busy length, a stream that starts on its own in standard layout, or a request honoured in infix layout, change busy or out_valid within a cycle or two of the triggering input.

// File: rtl/spare_asm_pkg.sv
package spare_asm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_PACK   = 2'd1,
      ST_STREAM = 2'd2
   } asm_state_e;

   // chunks of 512 data bytes per page for a page-size code
   function automatic int chunks_of(input logic [1:0] code);
      case (code)
         2'd0:    chunks_of = 1;
         2'd1:    chunks_of = 4;
         default: chunks_of = 8;
      endcase
   endfunction

   // spare-area length in bytes for a page-size code
   function automatic int spare_len(input logic [1:0] code);
      case (code)
         2'd0:    spare_len = 16;
         2'd1:    spare_len = 64;
         default: spare_len = 128;
      endcase
   endfunction

endpackage

// File: rtl/spare_ecc_packer.sv
module spare_ecc_packer #(
   parameter int SYM_W  = 10,
   parameter int SYM_N  = 8,
   parameter int RAW_W  = 32,
   parameter int HI_LSB = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic                          abort,
   input  logic [(SYM_N/2)*RAW_W-1:0]    raw,
   output logic                          active,
   output logic [$clog2(SYM_W*SYM_N/8)-1:0] byte_idx,
   output logic [7:0]                    byte_out,
   output logic                          last
);
   localparam int PACK_BITS  = SYM_W * SYM_N;
   localparam int PACK_BYTES = PACK_BITS / 8;
   localparam int K_W        = $clog2(PACK_BYTES);

   logic [PACK_BITS-1:0] dense;
   logic [PACK_BITS-1:0] sh_q;
   logic [K_W-1:0]       k_q;
   logic                 act_q;
   logic                 unused_raw;

   // two symbols per raw word: low field and high field, rest dropped
   for (genvar s = 0; s < SYM_N; s++) begin : g_sym
      assign dense[s*SYM_W +: SYM_W] = raw[(s/2)*RAW_W + (s%2)*HI_LSB +: SYM_W];
   end
   assign unused_raw = ^raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         k_q   <= '0;
         act_q <= 1'b0;
      end else if (abort) begin
         act_q <= 1'b0;
         k_q   <= '0;
      end else if (load) begin
         sh_q  <= dense;
         k_q   <= '0;
         act_q <= 1'b1;
      end else if (act_q) begin
         sh_q <= sh_q >> 8;
         k_q  <= k_q + 1'b1;
         if (k_q == K_W'(PACK_BYTES-1)) act_q <= 1'b0;
      end
   end

   assign active   = act_q;
   assign byte_idx = k_q;
   assign byte_out = sh_q[7:0];
   assign last     = act_q && (k_q == K_W'(PACK_BYTES-1));

endmodule

// File: rtl/spare_pos_map.sv
module spare_pos_map #(
   parameter int ADDR_W      = 7,
   parameter int K_W         = 4,
   parameter int CHUNK_W     = 4,
   parameter int INFIX_GROUP = 16,
   parameter int INFIX_PAD   = 6,
   parameter int BASE_2K     = 24,
   parameter int BASE_4K     = 48,
   parameter int STRIDE      = 10
) (
   input  logic [1:0]         size_code,
   input  logic               infix,
   input  logic [CHUNK_W-1:0] chunk,
   input  logic [K_W-1:0]     k,
   output logic [ADDR_W-1:0]  addr
);
   int a;

   always_comb begin
      if (infix) begin
         a = INFIX_GROUP * int'(chunk) + INFIX_PAD + int'(k);
      end else begin
         case (size_code)
            2'd0: begin
               // small page: skip marker byte and the five reserved bytes
               case (int'(k))
                  0, 1, 2, 3, 4: a = int'(k);
                  5:       a = 6;
                  6:       a = 7;
                  7:       a = 13;
                  8:       a = 14;
                  9:       a = 15;
                  default: a = 15;
               endcase
            end
            2'd1:    a = BASE_2K + STRIDE * int'(chunk) + int'(k);
            default: a = BASE_4K + STRIDE * int'(chunk) + int'(k);
         endcase
      end
      addr = ADDR_W'(a);
   end

endmodule

// File: rtl/spare_buffer.sv
module spare_buffer #(
   parameter int BYTES  = 128,
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata
);
   logic [7:0] mem [BYTES];

   for (genvar i = 0; i < BYTES; i++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                mem[i] <= 8'hFF;
         else if (fill)                             mem[i] <= 8'hFF;
         else if (we && (waddr == ADDR_W'(i)))      mem[i] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/spare_ecc_assembler.sv
module spare_ecc_assembler
   import spare_asm_pkg::*;
#(
   parameter int SPARE_BYTES = 128,
   parameter int SYM_W       = 10,
   parameter int SYM_N       = 8,
   parameter int RAW_W       = 32,
   parameter int HI_LSB      = 16,
   parameter int INFIX_GROUP = 16,
   parameter int INFIX_PAD   = 6,
   parameter int MAX_CHUNKS  = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         page_start,
   input  logic [1:0]                   page_size,
   input  logic                         infix_mode,
   input  logic                         sup_we,
   input  logic [$clog2(SPARE_BYTES)-1:0] sup_addr,
   input  logic [7:0]                   sup_data,
   input  logic                         chunk_done,
   input  logic [(SYM_N/2)*RAW_W-1:0]   ecc_raw,
   input  logic                         read_req,
   output logic                         busy,
   output logic                         out_valid,
   output logic [7:0]                   out_data,
   output logic                         out_last
);
   localparam int ADDR_W     = $clog2(SPARE_BYTES);
   localparam int PACK_BYTES = SYM_W * SYM_N / 8;
   localparam int K_W        = $clog2(PACK_BYTES);
   localparam int CHUNK_W    = $clog2(MAX_CHUNKS + 1);

   // elaboration-time parameter checks
   if ((SYM_W * SYM_N) % 8 != 0) begin : g_bad_bits
      $error("symbol bits must fill whole bytes");
   end
   if (PACK_BYTES != 10) begin : g_bad_pack
      $error("position layouts assume ten ECC bytes per chunk");
   end
   if (SPARE_BYTES < 128) begin : g_bad_spare
      $error("spare buffer must hold the largest spare area");
   end
   if (SYM_W > HI_LSB || HI_LSB + SYM_W > RAW_W) begin : g_bad_fields
      $error("symbol fields do not fit the raw word");
   end
   if (INFIX_PAD + PACK_BYTES != INFIX_GROUP) begin : g_bad_group
      $error("infix group must be pad plus ECC bytes");
   end
   if (MAX_CHUNKS < 8 || MAX_CHUNKS * INFIX_GROUP > SPARE_BYTES) begin : g_bad_chunks
      $error("chunk count does not match the spare buffer");
   end

   asm_state_e          state_q;
   logic [1:0]          size_q;
   logic                infix_q;
   logic [CHUNK_W-1:0]  chunk_q;
   logic [CHUNK_W-1:0]  cur_q;
   logic [ADDR_W-1:0]   rd_ptr_q;
   logic [ADDR_W-1:0]   rd_end_q;

   logic                idle;
   logic                chunk_ok;
   logic                read_ok;
   logic                sup_ok;
   logic                pk_active;
   logic                pk_last;
   logic [K_W-1:0]      pk_idx;
   logic [7:0]          pk_byte;
   logic [ADDR_W-1:0]   pk_addr;
   logic                buf_we;
   logic [ADDR_W-1:0]   buf_waddr;
   logic [7:0]          buf_wdata;
   logic [7:0]          buf_rdata;

   assign idle     = (state_q == ST_IDLE);
   assign chunk_ok = chunk_done && idle && !page_start
                     && (int'(chunk_q) < chunks_of(size_q));
   assign read_ok  = read_req && idle && !page_start && !infix_q && !chunk_ok;
   assign sup_ok   = sup_we && idle && !page_start;

   spare_ecc_packer #(
      .SYM_W (SYM_W),
      .SYM_N (SYM_N),
      .RAW_W (RAW_W),
      .HI_LSB(HI_LSB)
   ) u_packer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (chunk_ok),
      .abort   (page_start),
      .raw     (ecc_raw),
      .active  (pk_active),
      .byte_idx(pk_idx),
      .byte_out(pk_byte),
      .last    (pk_last)
   );

   spare_pos_map #(
      .ADDR_W     (ADDR_W),
      .K_W        (K_W),
      .CHUNK_W    (CHUNK_W),
      .INFIX_GROUP(INFIX_GROUP),
      .INFIX_PAD  (INFIX_PAD)
   ) u_pos (
      .size_code(size_q),
      .infix    (infix_q),
      .chunk    (cur_q),
      .k        (pk_idx),
      .addr     (pk_addr)
   );

   assign buf_we    = pk_active || sup_ok;
   assign buf_waddr = pk_active ? pk_addr : sup_addr;
   assign buf_wdata = pk_active ? pk_byte : sup_data;

   spare_buffer #(
      .BYTES (SPARE_BYTES),
      .ADDR_W(ADDR_W)
   ) u_buf (
      .clk  (clk),
      .rst_n(rst_n),
      .fill (page_start),
      .we   (buf_we),
      .waddr(buf_waddr),
      .wdata(buf_wdata),
      .raddr(rd_ptr_q),
      .rdata(buf_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         size_q   <= 2'd0;
         infix_q  <= 1'b0;
         chunk_q  <= '0;
         cur_q    <= '0;
         rd_ptr_q <= '0;
         rd_end_q <= '0;
      end else if (page_start) begin
         state_q <= ST_IDLE;
         size_q  <= page_size;
         infix_q <= infix_mode;
         chunk_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (chunk_ok) begin
                  state_q <= ST_PACK;
                  cur_q   <= chunk_q;
                  chunk_q <= chunk_q + 1'b1;
               end else if (read_ok) begin
                  state_q  <= ST_STREAM;
                  rd_ptr_q <= '0;
                  rd_end_q <= ADDR_W'(spare_len(size_q) - 1);
               end
            end
            ST_PACK: begin
               if (pk_last) begin
                  if (infix_q) begin
                     state_q  <= ST_STREAM;
                     rd_ptr_q <= ADDR_W'(INFIX_GROUP * int'(cur_q));
                     rd_end_q <= ADDR_W'(INFIX_GROUP * int'(cur_q) + INFIX_GROUP - 1);
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            ST_STREAM: begin
               if (rd_ptr_q == rd_end_q) state_q  <= ST_IDLE;
               else                      rd_ptr_q <= rd_ptr_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = !idle;
   assign out_valid = (state_q == ST_STREAM);
   assign out_data  = buf_rdata;
   assign out_last  = out_valid && (rd_ptr_q == rd_end_q);

endmodule

// File: rtl/spare_ecc_assembler_chk.sv
module spare_ecc_assembler_chk
   import spare_asm_pkg::*;
#(
   parameter int PACK_BYTES = 10
) (
   input logic       clk,
   input logic       rst_n,
   input logic       page_start,
   input logic [1:0] page_size,
   input logic       infix_mode,
   input logic       chunk_done,
   input logic       read_req,
   input logic       busy,
   input logic       out_valid,
   input logic       out_last
);
   logic [1:0] sz_q;
   logic       inf_q;
   int         cnt_q;
   int         run_q;
   logic       at_limit;

   assign at_limit = (cnt_q >= chunks_of(sz_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sz_q  <= 2'd0;
         inf_q <= 1'b0;
         cnt_q <= 0;
         run_q <= 0;
      end else begin
         if (page_start) begin
            sz_q  <= page_size;
            inf_q <= infix_mode;
            cnt_q <= 0;
         end else if (chunk_done && !busy && !at_limit) begin
            cnt_q <= cnt_q + 1;
         end
         if (busy && !out_valid) run_q <= run_q + 1;
         else                    run_q <= 0;
      end
   end

   AST_PACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !out_valid) |-> (run_q < PACK_BYTES)); // R9

   AST_EXTRA_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
      (chunk_done && !busy && !page_start && !read_req && at_limit) |=> !busy); // R10

   AST_INFIX_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (inf_q && read_req && !busy && !chunk_done && !page_start) |=> !busy); // R7

   AST_LAST_IN_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid); // R8

   AST_STD_STREAM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!inf_q && $rose(out_valid)) |-> $past(read_req)); // R8

   AST_INFIX_AFTER_PACK: assert property (@(posedge clk) disable iff (!rst_n)
      (inf_q && $rose(out_valid)) |-> ($past(busy) && !$past(read_req && !busy))); // R6

endmodule

bind spare_ecc_assembler spare_ecc_assembler_chk #(
   .PACK_BYTES(SYM_W * SYM_N / 8)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .page_start(page_start),
   .page_size (page_size),
   .infix_mode(infix_mode),
   .chunk_done(chunk_done),
   .read_req  (read_req),
   .busy      (busy),
   .out_valid (out_valid),
   .out_last  (out_last)
);

// File: tb/spare_ecc_assembler_test.sv
`timescale 1ns/1ps
module spare_ecc_assembler_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         page_start = 1'b0;
   logic [1:0]   page_size = 2'd0;
   logic         infix_mode = 1'b0;
   logic         sup_we = 1'b0;
   logic [6:0]   sup_addr = '0;
   logic [7:0]   sup_data = '0;
   logic         chunk_done = 1'b0;
   logic [127:0] ecc_raw = '0;
   logic         read_req = 1'b0;
   logic         busy, out_valid, out_last;
   logic [7:0]   out_data;

   int total = 0;
   int fails = 0;

   logic [7:0] ref_m [128];
   int ref_size = 0;
   int ref_inf  = 0;
   int ref_cnt  = 0;

   always #10 clk = ~clk;

   spare_ecc_assembler uut (
      .clk(clk), .rst_n(rst_n), .page_start(page_start), .page_size(page_size),
      .infix_mode(infix_mode), .sup_we(sup_we), .sup_addr(sup_addr), .sup_data(sup_data),
      .chunk_done(chunk_done), .ecc_raw(ecc_raw), .read_req(read_req),
      .busy(busy), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic int lim_of(input int sz);
      return (sz == 0) ? 1 : (sz == 1) ? 4 : 8;
   endfunction

   function automatic int len_of(input int sz);
      return (sz == 0) ? 16 : (sz == 1) ? 64 : 128;
   endfunction

   // R2: dense packing, symbol 2w from word w bits 9:0, 2w+1 from 25:16
   function automatic logic [79:0] pack_ref(input logic [127:0] raw);
      logic [79:0] r;
      for (int b = 0; b < 80; b++) begin
         int sym = b / 10;
         r[b] = raw[(sym / 2) * 32 + (sym % 2) * 16 + (b % 10)];
      end
      return r;
   endfunction

   // R3 / R4 / R6 positions
   function automatic int pos_ref(input int sz, input int inf, input int c, input int k);
      int small_tab [10] = '{0, 1, 2, 3, 4, 6, 7, 13, 14, 15};
      if (inf != 0) return 16 * c + 6 + k;
      if (sz == 0)  return small_tab[k];
      if (sz == 1)  return 24 + 10 * c + k;
      return 48 + 10 * c + k;
   endfunction

   task automatic start_page(input int sz, input int inf);
      @(negedge clk);
      page_start = 1'b1; page_size = 2'(sz); infix_mode = inf[0];
      @(negedge clk);
      page_start = 1'b0;
      for (int i = 0; i < 128; i++) ref_m[i] = 8'hFF;
      ref_size = (sz == 3) ? 2 : sz;
      ref_inf = inf;
      ref_cnt = 0;
   endtask

   task automatic supply(input int a, input logic [7:0] d);
      @(negedge clk);
      sup_we = 1'b1; sup_addr = 7'(a); sup_data = d;
      @(negedge clk);
      sup_we = 1'b0;
      ref_m[a] = d;
   endtask

   task automatic do_chunk(input logic [127:0] raw, input bit intrude);
      bit acc;
      int c, n, nv, exp_n;
      logic [79:0] p;
      acc = (ref_cnt < lim_of(ref_size));
      c = ref_cnt;
      if (acc) begin
         p = pack_ref(raw);
         for (int k = 0; k < 10; k++) ref_m[pos_ref(ref_size, ref_inf, c, k)] = p[8*k +: 8];
         ref_cnt++;
      end
      @(negedge clk);
      chunk_done = 1'b1; ecc_raw = raw;
      @(negedge clk);
      chunk_done = 1'b0; ecc_raw = {$urandom, $urandom, $urandom, $urandom};
      n = 0; nv = 0;
      while (busy && n < 100) begin
         if (out_valid) begin
            chk(out_data == ref_m[16 * c + nv], "R6 infix byte", out_data, ref_m[16 * c + nv]);
            chk(out_last == (nv == 15), "R6 infix last", out_last, nv == 15);
            nv++;
         end
         n++;
         if (intrude && n == 3) chunk_done = 1'b1;   // R11 strobe while busy
         if (intrude && n == 4) chunk_done = 1'b0;
         @(negedge clk);
      end
      chunk_done = 1'b0;
      exp_n = !acc ? 0 : (ref_inf != 0) ? 26 : 10;
      chk(n == exp_n, acc ? "R9 busy length" : "R10 extra chunk busy", n, exp_n);
      chk(nv == ((acc && ref_inf != 0) ? 16 : 0), "R6 infix stream length", nv,
          (acc && ref_inf != 0) ? 16 : 0);
   endtask

   task automatic read_spare(input string req);
      int n, nv, len;
      len = (ref_inf != 0) ? 0 : len_of(ref_size);
      @(negedge clk);
      read_req = 1'b1;
      @(negedge clk);
      read_req = 1'b0;
      n = 0; nv = 0;
      while ((busy || n < 3) && n < 300) begin
         if (out_valid) begin
            if (nv < 128)
               chk(out_data == ref_m[nv], req, out_data, ref_m[nv]);
            chk(out_last == (nv == len - 1), "R8 last flag", out_last, nv == len - 1);
            nv++;
         end
         n++;
         @(negedge clk);
      end
      chk(nv == len, (ref_inf != 0) ? "R7 read ignored in infix" : "R8 stream length", nv, len);
   endtask

   task automatic fill_page(input bit intrude_first);
      for (int c = 0; c < lim_of(ref_size); c++)
         do_chunk({$urandom, $urandom, $urandom, $urandom}, intrude_first && c == 0);
   endtask

   initial begin
      #(20 * 150000);
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      void'($urandom(32'h5A17));
      for (int i = 0; i < 128; i++) ref_m[i] = 8'hFF;
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && out_valid == 1'b0, "R1 reset outputs", {busy, out_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      read_spare("R1 reset buffer is 0xFF");

      // small page: one chunk with junk in masked bits, marker untouched
      start_page(0, 0);
      do_chunk(128'hFFFF_FFFF_FC00_FC00_A5A5_5A5A_0123_4567, 1'b0);
      read_spare("R3 small page layout / R2 packing");
      do_chunk(128'h0, 1'b0);                       // R10 beyond one chunk
      read_spare("R10 buffer unchanged after extra chunk");

      // large pages
      start_page(1, 0);
      read_spare("R1 page start refills 0xFF");
      fill_page(1'b1);                              // R11 strobe during pack
      read_spare("R4 2048 layout");
      do_chunk({$urandom, $urandom, $urandom, $urandom}, 1'b0);   // R10
      start_page(2, 0);
      for (int i = 0; i < 12; i++) supply($urandom % 48, 8'($urandom));
      supply(5, 8'h3C);
      fill_page(1'b0);
      read_spare("R5 supplied bytes kept / R4 4096 layout");
      start_page(3, 0);
      fill_page(1'b0);
      read_spare("R4 code 3 as 4096 layout");

      // infix layouts
      start_page(1, 1);
      for (int i = 0; i < 4; i++) supply(16 * i + (i % 6), 8'h11 * (i + 1));
      fill_page(1'b0);
      read_spare("R7 infix read");
      start_page(0, 1);
      fill_page(1'b0);
      do_chunk(128'h1, 1'b0);                       // R10 in infix

      // constrained random pages
      for (int pg = 0; pg < 24; pg++) begin
         int sz = $urandom % 4;
         int inf = $urandom % 2;
         int nsup = $urandom % 6;
         int nch;
         start_page(sz, inf);
         for (int s = 0; s < nsup; s++) supply($urandom % len_of(ref_size), 8'($urandom));
         nch = $urandom % (lim_of(ref_size) + 2);
         for (int c = 0; c < nch; c++)
            do_chunk({$urandom, $urandom, $urandom, $urandom}, ($urandom % 4) == 0);
         read_spare((ref_size == 0) ? "R3 random small page" : "R4 random large page");
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule